// File: doc/BRIEF.md
# Change-of-state input port detector

This block looks after the four general-purpose I/O pins of one serial channel. Every pin is brought into the system clock domain through a synchroniser. It is then qualified by a slow filter that only acts on a sample strobe, a one-cycle pulse that stands in for a low-rate sample clock. A new level counts as a change of state only after it has been seen on a set number of consecutive strobes. A qualified change on a pin whose detector is enabled sets a sticky flag. The flag stays set until software reads the status register.

Software sets up the pins through one read/write control register, which holds the drive level, the output enable and the detector enable of each pin. A pin that drives an output never raises a flag. A read-only status register gives the live pin levels and the flags, and a read of it clears the flags that it returns. A registered summary output is high while any flag is set, so it can feed an interrupt source.

Top module: `cos_port_watch`

## Requirements
- R1: After reset, pin_oe, pin_out, cos_irq and reg_rdata are all zero.
- R2: A change is recognised only on the second consecutive sample strobe at which the synchronised pin level differs from the accepted level. A level that returns before that strobe, or that is seen on a single strobe only, sets no flag.
- R3: The first sample strobe after reset loads the current pin levels as the accepted levels and sets no flag.
- R4: A status read (reg_addr = 1) returns the synchronised pin levels in bits [3:0] and the flags in bits [7:4], with zeros above. It clears every flag it returned.
- R5: A change that sets a flag in the same cycle as a clearing status read is kept, and the next status read reports it.
- R6: A control write (reg_addr = 0) takes the drive levels from bits [3:0], the output enables from bits [7:4] (1 = drive) and the detector enables from bits [11:8]. pin_out and pin_oe show the new values from the next cycle.
- R7: A pin with its output enable set has its flag cleared and sets no new flag while it drives.
- R8: A pin whose detector enable is 0 sets no flag when its level changes.
- R9: A control read returns the pin levels in bits [3:0], the output enables in bits [7:4] and the flags in bits [11:8]. It does not clear any flag.
- R10: cos_irq is high in the cycle after any flag is set, and low in the cycle after no flag is set.
- R11: reg_rdata carries the read result from the clock edge at which reg_rd is sampled high, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-cycle sample strobe at the slow sample rate |
| pin_in | input | 4 | Pin levels from the pads |
| pin_out | output | 4 | Level driven on each pin |
| pin_oe | output | 4 | Output enable per pin, 1 = drive |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = control register, 1 = status register |
| reg_wdata | input | 12 | Write data |
| reg_rdata | output | 12 | Registered read data |
| cos_irq | output | 1 | High while any change flag is set |

## Verification
The bench builds the block with its defaults: four pins, a two-stage synchroniser and a qualification count of two strobes. The strobe is a bench-driven pulse, so the bench can place strobes a few cycles apart. This brings glitch rejection, single-strobe rejection and the end of qualification within a few hundred cycles. Because the strobe cycle is under bench control, a qualifying strobe can also be lined up so that the flag sets in the same cycle as a clearing status read.

// File: rtl/cos_port_pkg.sv
package cos_port_pkg;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cos_filter.sv
module cos_filter #(
  parameter int QUAL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic level,
  output logic chg
);
  localparam int CW = (QUAL > 1) ? $clog2(QUAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL - 1);

  logic [CW-1:0] cnt;
  logic          primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      level  <= 1'b0;
      cnt    <= '0;
      primed <= 1'b0;
      chg    <= 1'b0;
    end else begin
      chg <= 1'b0;
      if (tick) begin
        if (!primed) begin
          level  <= din;
          primed <= 1'b1;
          cnt    <= '0;
        end else if (din == level) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          level <= din;
          cnt   <= '0;
          chg   <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2: a change pulse only follows a sample strobe
  a_r2_chg_after_tick: assert property (@(posedge clk) disable iff (rst)
    chg |-> $past(tick));
  // R2: a change pulse always comes with a new accepted level
  a_r2_chg_new_level: assert property (@(posedge clk) disable iff (rst)
    chg |-> (level != $past(level)));
  // R2: accepted level only moves on a strobe
  a_r2_level_stable: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(level));
endmodule

// File: rtl/cos_flags.sv
module cos_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] keep,
  output logic [N-1:0] flags,
  output logic         any
);
  logic [N-1:0] flags_n;

  always_comb flags_n = (flags & ~clr & keep) | (set & keep);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      any   <= 1'b0;
    end else begin
      flags <= flags_n;
      any   <= |flags;
    end
  end

  // R5: a set request survives a simultaneous clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|(set & keep)) |=> ((flags & $past(set & keep)) == $past(set & keep)));
  // R10: summary follows the flags one cycle later
  a_r10_irq_high: assert property (@(posedge clk) disable iff (rst)
    (|flags) |=> any);
  a_r10_irq_low: assert property (@(posedge clk) disable iff (rst)
    !(|flags) |=> !any);
endmodule

// File: rtl/cos_port_watch.sv
module cos_port_watch #(
  parameter int NPINS       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_TICKS  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_tick,
  input  logic [NPINS-1:0]     pin_in,
  output logic [NPINS-1:0]     pin_out,
  output logic [NPINS-1:0]     pin_oe,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic                 reg_addr,
  input  logic [3*NPINS-1:0]   reg_wdata,
  output logic [3*NPINS-1:0]   reg_rdata,
  output logic                 cos_irq
);
  import cos_port_pkg::*;

  localparam int RW = 3 * NPINS;

  logic [NPINS-1:0] pin_sync;
  logic [NPINS-1:0] acc_level;
  logic [NPINS-1:0] chg;
  logic [NPINS-1:0] en_q;
  logic [NPINS-1:0] en_eff;
  logic [NPINS-1:0] flags;
  logic [NPINS-1:0] clr_mask;
  logic             stat_rd;
  logic             ctrl_wr;

  cos_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    cos_filter #(.QUAL(QUAL_TICKS)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .tick  (sample_tick),
      .din   (pin_sync[i]),
      .level (acc_level[i]),
      .chg   (chg[i])
    );
  end

  assign ctrl_wr  = reg_wr && (reg_addr == ADDR_CTRL);
  assign stat_rd  = reg_rd && (reg_addr == ADDR_STAT);
  assign en_eff   = en_q & ~pin_oe;
  assign clr_mask = stat_rd ? flags : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      pin_oe  <= '0;
      en_q    <= '0;
    end else if (ctrl_wr) begin
      pin_out <= reg_wdata[NPINS-1:0];
      pin_oe  <= reg_wdata[2*NPINS-1:NPINS];
      en_q    <= reg_wdata[3*NPINS-1:2*NPINS];
    end
  end

  cos_flags #(.N(NPINS)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set   (chg),
    .clr   (clr_mask),
    .keep  (en_eff),
    .flags (flags),
    .any   (cos_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (reg_addr == ADDR_CTRL)
        reg_rdata <= {flags, pin_oe, pin_sync};
      else
        reg_rdata <= {{(RW-2*NPINS){1'b0}}, flags, pin_sync};
    end
  end

  // R7: a driving pin carries no flag one cycle later
  a_r7_output_no_flag: assert property (@(posedge clk) disable iff (rst)
    (|pin_oe) |=> ((flags & $past(pin_oe)) == '0));
  // R8: a disabled detector carries no flag one cycle later
  a_r8_disabled_no_flag: assert property (@(posedge clk) disable iff (rst)
    (|(~en_q)) |=> ((flags & ~$past(en_q)) == '0));
  // R4: a status read with no new change leaves no flag
  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !(|chg)) |=> (flags == '0));
  // R9: a control read never drops a flag
  a_r9_ctrl_read_keeps: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_CTRL && !ctrl_wr) |=> ((flags & $past(flags)) == $past(flags)));
  // R11: read data only moves after a read
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(reg_rd) |-> $stable(reg_rdata));
endmodule

// File: tb/cos_port_watch_test.sv
module cos_port_watch_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sample_tick = 1'b0;
  logic [3:0]  pin_in = 4'b0101;
  logic [3:0]  pin_out, pin_oe;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [11:0] reg_wdata = '0;
  logic [11:0] reg_rdata;
  logic        cos_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [11:0] rd;

  always #4 clk = ~clk;

  cos_port_watch uut (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cos_irq(cos_irq)
  );

  // {pins, strobes, expected flags}; levels expected equal pins
  localparam logic [11:0] VEC [7] = '{
    {4'b0001, 4'd2, 4'b0001},  // R2 single rising edge
    {4'b0001, 4'd2, 4'b0000},  // R4 cleared, no new change
    {4'b0110, 4'd1, 4'b0000},  // R2 one strobe is not enough
    {4'b0110, 4'd1, 4'b0111},  // R2 second strobe qualifies
    {4'b1110, 4'd1, 4'b0000},  // R2 glitch begins
    {4'b0110, 4'd2, 4'b0000},  // R2 glitch rejected
    {4'b1001, 4'd3, 4'b1111}   // R2 all pins change
  };

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) sample_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_pins(input logic [3:0] p);
    @(negedge clk) pin_in = p;
    repeat (4) @(negedge clk);
  endtask

  task automatic reg_read(input logic a, output logic [11:0] d);
    @(negedge clk) begin reg_rd = 1'b1; reg_addr = a; end
    @(negedge clk) reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic reg_write(input logic [11:0] w);
    @(negedge clk) begin reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = w; end
    @(negedge clk) reg_wr = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pin_oe", {8'd0, pin_oe}, 12'd0);
    check("R1 pin_out", {8'd0, pin_out}, 12'd0);
    check("R1 cos_irq", {11'd0, cos_irq}, 12'd0);
    check("R1 reg_rdata", reg_rdata, 12'd0);

    reg_write({4'hF, 4'h0, 4'h0});
    repeat (3) @(negedge clk);
    strobe();
    reg_read(1'b1, rd);
    check("R3 first strobe primes", rd, {4'd0, 4'b0000, 4'b0101});
    set_pins(4'b0000);
    strobe(); strobe();
    reg_read(1'b1, rd);
    check("R3 change from primed level", rd, {4'd0, 4'b0101, 4'b0000});

    for (int k = 0; k < 7; k++) begin
      set_pins(VEC[k][11:8]);
      for (int t = 0; t < int'(VEC[k][7:4]); t++) strobe();
      reg_read(1'b1, rd);
      check("R2/R4 vector", rd, {4'd0, VEC[k][3:0], VEC[k][11:8]});
    end

    // R10 and R9: pin0 falls, accepted 1001 -> 1000
    set_pins(4'b1000);
    strobe(); strobe();
    check("R10 irq high", {11'd0, cos_irq}, 12'd1);
    reg_read(1'b0, rd);
    check("R9 control read", rd, {4'b0001, 4'b0000, 4'b1000});
    reg_read(1'b1, rd);
    check("R9 flag kept after control read", rd, {4'd0, 4'b0001, 4'b1000});
    @(negedge clk);
    check("R10 irq low", {11'd0, cos_irq}, 12'd0);

    // R8: pin1 detector off
    reg_write({4'b1101, 4'h0, 4'h0});
    set_pins(4'b1010);
    strobe(); strobe();
    check("R8 irq stays low", {11'd0, cos_irq}, 12'd0);
    reg_read(1'b1, rd);
    check("R8 no flag", rd, {4'd0, 4'b0000, 4'b1010});

    // R6 and R7: raise pin2 flag, then make pin2 an output
    set_pins(4'b1110);
    strobe(); strobe();
    reg_write({4'hF, 4'b0100, 4'b0100});
    check("R6 pin_oe", {8'd0, pin_oe}, {8'd0, 4'b0100});
    check("R6 pin_out", {8'd0, pin_out}, {8'd0, 4'b0100});
    reg_read(1'b1, rd);
    check("R7 flag dropped", rd, {4'd0, 4'b0000, 4'b1110});
    set_pins(4'b1010);
    strobe(); strobe();
    reg_read(1'b1, rd);
    check("R7 no flag while driving", rd, {4'd0, 4'b0000, 4'b1010});

    // R5: change sets flag in the same cycle as a clearing read
    reg_write({4'hF, 4'h0, 4'h0});
    check("R6 pin_oe released", {8'd0, pin_oe}, 12'd0);
    set_pins(4'b1011);
    strobe();
    @(negedge clk) sample_tick = 1'b1;
    @(negedge clk) begin sample_tick = 1'b0; reg_rd = 1'b1; reg_addr = 1'b1; end
    @(negedge clk) reg_rd = 1'b0;
    check("R5 R11 read in collision cycle", reg_rdata, {4'd0, 4'b0000, 4'b1011});
    reg_read(1'b1, rd);
    check("R5 flag kept", rd, {4'd0, 4'b0001, 4'b1011});
    repeat (3) @(negedge clk);
    check("R11 rdata held", reg_rdata, {4'd0, 4'b0001, 4'b1011});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule